// File: doc/BRIEF.md
# Battery-Backed SRAM Controller Gate

This block stands between a host bus and two byte-wide targets: an external static memory and a bank of sixteen timekeeping registers. It decodes a 19-bit byte address. The sixteen highest addresses (7FFF0h to 7FFFFh) belong to the register bank, whatever memory size is fitted. Every other address goes to the external memory. The host's active-low chip enable, output enable and write enable are turned into gated enables for the external memory, one-hot read and write strobes for the register bank, and a read-data selection with its own drive-enable for the shared data bus.

Because the register window overlaps the top of the external memory map, the external output enable is held inactive during register accesses. The host therefore sees one continuous map with no two drivers on the bus. A power-fail input blocks every write at once, to both targets, and it also removes the external chip enable, even partway through a cycle. The whole path is combinational, so a change of address moves the external output enable within the same cycle.

Top module: `bbsg_top`

## Requirements
- R1: An address whose bits 18..4 are all ones (7FFF0h to 7FFFFh) selects the register bank, and `reg_idx_o` equals address bits 3..0. Every other address selects the external memory.
- R2: A write cycle is chip enable low and write enable low, whatever the output enable. In the register window, with power good, it raises exactly bit `reg_idx_o` of `reg_wr_stb_o`.
- R3: A read cycle is chip enable low and write enable high. In the register window it raises exactly bit `reg_idx_o` of `reg_rd_stb_o`. Outside the window, or with no read cycle, `reg_rd_stb_o` is zero.
- R4: While the address is in the register window, `ext_oe_n_o` is 1 (inactive), whatever the level of `oe_n_i`.
- R5: Outside the register window, `ext_oe_n_o` equals `oe_n_i`. A move of the address into the window raises `ext_oe_n_o` with no clock edge between.
- R6: While `pwr_fail_i` is 1, `reg_wr_stb_o` is zero and both `ext_we_n_o` and `ext_ce_n_o` are 1, including when the flag rises during a cycle already under way.
- R7: While `pwr_fail_i` is 0, `ext_ce_n_o` equals `ce_n_i`.
- R8: `rdata_oe_o` is 1 only when chip enable is low, write enable is high and output enable is low. Otherwise it is 0 and the data bus floats.
- R9: `rdata_o` carries `reg_rdata_i` for addresses in the register window and `mem_rdata_i` for all other addresses.
- R10: An external write (`ext_we_n_o` = 0) takes place only for a memory-range write cycle with power good. A register write leaves `ext_we_n_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 19 | Host byte address |
| ce_n_i | input | 1 | Host chip enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| pwr_fail_i | input | 1 | Supply out of tolerance, active high |
| mem_rdata_i | input | 8 | Read data from the external memory |
| reg_rdata_i | input | 8 | Read data from the selected register |
| ext_ce_n_o | output | 1 | Gated chip enable to the external memory, active low |
| ext_oe_n_o | output | 1 | Gated output enable to the external memory, active low |
| ext_we_n_o | output | 1 | Gated write enable to the external memory, active low |
| reg_idx_o | output | 4 | Register slot addressed |
| reg_wr_stb_o | output | 16 | One-hot register write strobes |
| reg_rd_stb_o | output | 16 | One-hot register read strobes |
| rdata_o | output | 8 | Read data toward the host bus |
| rdata_oe_o | output | 1 | Drive enable for the host data bus |

## Verification
The embedded assertions check these rules whenever the inputs settle:
- at most one register write strobe is active;
- a register write never reaches the external write enable;
- the window keeps the external output enable off;
- power failure suppresses every write and the external chip enable;
- the data bus is never driven during a write.

Only the bench's scenarios can show the rest:
- that the correct strobe bit follows the address across all sixteen slots;
- that the read-data source switches exactly at the 7FFEFh to 7FFF0h boundary;
- that the output enable drops in the same cycle as an address move into the window;
- that power failure cuts off a write already in progress.

// File: rtl/bbsg_pkg.sv
package bbsg_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Host cycle kind from the active-low enables; output enable plays no part.
  function automatic cyc_e classify(input logic ce_n, input logic we_n);
    if (ce_n)      return CYC_IDLE;
    else if (we_n) return CYC_READ;
    else           return CYC_WRITE;
  endfunction

  // True when every address bit above the slot field is set.
  function automatic logic upper_all_ones(input logic [31:0] upper_bits,
                                          input int unsigned width);
    logic acc;
    acc = 1'b1;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < width) acc = acc & upper_bits[k];
    end
    return acc;
  endfunction

endpackage

// File: rtl/bbsg_decode.sv
module bbsg_decode #(
  parameter int ADDR_W  = 19,
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT),
  localparam int UP_W   = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic [IDX_W-1:0]  slot
);
  import bbsg_pkg::*;

  logic [31:0] upper_ext;

  always_comb begin
    upper_ext = '0;
    upper_ext[UP_W-1:0] = addr[ADDR_W-1:IDX_W];
    in_window = upper_all_ones(upper_ext, UP_W);
    slot      = addr[IDX_W-1:0];
  end

endmodule

// File: rtl/bbsg_cycle.sv
module bbsg_cycle (
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             pwr_fail,
  output bbsg_pkg::cyc_e   cyc,
  output logic             write_ok,
  output logic             drive_bus
);
  import bbsg_pkg::*;

  always_comb begin
    cyc       = classify(ce_n, we_n);
    write_ok  = (cyc == CYC_WRITE) && !pwr_fail;
    drive_bus = (cyc == CYC_READ) && !oe_n;
  end

endmodule

// File: rtl/bbsg_ext_gate.sv
module bbsg_ext_gate (
  input  logic ce_n,
  input  logic oe_n,
  input  logic pwr_fail,
  input  logic in_window,
  input  logic write_ok,
  output logic ext_ce_n,
  output logic ext_oe_n,
  output logic ext_we_n
);

  always_comb begin
    ext_ce_n = ce_n | pwr_fail;
    ext_oe_n = oe_n | in_window;
    ext_we_n = !(write_ok && !in_window);
  end

endmodule

// File: rtl/bbsg_strobe.sv
module bbsg_strobe #(
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic               in_window,
  input  logic [IDX_W-1:0]   slot,
  input  bbsg_pkg::cyc_e     cyc,
  input  logic               write_ok,
  output logic [REG_CNT-1:0] wr_stb,
  output logic [REG_CNT-1:0] rd_stb
);
  import bbsg_pkg::*;

  logic rd_sel;
  logic wr_sel;

  always_comb begin
    rd_sel = in_window && (cyc == CYC_READ);
    wr_sel = in_window && write_ok;
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_slot
    logic hit;
    always_comb begin
      hit       = (slot == IDX_W'(g));
      wr_stb[g] = wr_sel && hit;
      rd_stb[g] = rd_sel && hit;
    end
  end

endmodule

// File: rtl/bbsg_rmux.sv
module bbsg_rmux #(
  parameter int DATA_W = 8
) (
  input  logic              in_window,
  input  logic              drive_bus,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  always_comb begin
    rdata    = in_window ? reg_rdata : mem_rdata;
    rdata_oe = drive_bus;
  end

endmodule

// File: rtl/bbsg_top.sv
module bbsg_top #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               ce_n_i,
  input  logic               oe_n_i,
  input  logic               we_n_i,
  input  logic               pwr_fail_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  input  logic [DATA_W-1:0]  reg_rdata_i,
  output logic               ext_ce_n_o,
  output logic               ext_oe_n_o,
  output logic               ext_we_n_o,
  output logic [IDX_W-1:0]   reg_idx_o,
  output logic [REG_CNT-1:0] reg_wr_stb_o,
  output logic [REG_CNT-1:0] reg_rd_stb_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rdata_oe_o
);
  import bbsg_pkg::*;

  // Named internal events, brought out for the assertions below.
  logic           in_window;
  logic [IDX_W-1:0] slot;
  cyc_e           cyc;
  logic           write_ok;
  logic           drive_bus;

  bbsg_decode #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT)) u_decode (
    .addr(addr_i), .in_window(in_window), .slot(slot)
  );

  bbsg_cycle u_cycle (
    .ce_n(ce_n_i), .oe_n(oe_n_i), .we_n(we_n_i), .pwr_fail(pwr_fail_i),
    .cyc(cyc), .write_ok(write_ok), .drive_bus(drive_bus)
  );

  bbsg_ext_gate u_gate (
    .ce_n(ce_n_i), .oe_n(oe_n_i), .pwr_fail(pwr_fail_i),
    .in_window(in_window), .write_ok(write_ok),
    .ext_ce_n(ext_ce_n_o), .ext_oe_n(ext_oe_n_o), .ext_we_n(ext_we_n_o)
  );

  bbsg_strobe #(.REG_CNT(REG_CNT)) u_strobe (
    .in_window(in_window), .slot(slot), .cyc(cyc), .write_ok(write_ok),
    .wr_stb(reg_wr_stb_o), .rd_stb(reg_rd_stb_o)
  );

  bbsg_rmux #(.DATA_W(DATA_W)) u_rmux (
    .in_window(in_window), .drive_bus(drive_bus),
    .mem_rdata(mem_rdata_i), .reg_rdata(reg_rdata_i),
    .rdata(rdata_o), .rdata_oe(rdata_oe_o)
  );

  assign reg_idx_o = slot;

  // Cross-module rules, checked whenever the inputs are known.
  always_comb begin
    if (!$isunknown({addr_i, ce_n_i, oe_n_i, we_n_i, pwr_fail_i})) begin
      p_wr_onehot_r2: assert ($onehot0(reg_wr_stb_o))
        else $error("R2: more than one register write strobe");
      p_rd_onehot_r3: assert ($onehot0(reg_rd_stb_o))
        else $error("R3: more than one register read strobe");
      p_window_oe_off_r4: assert (!in_window || ext_oe_n_o)
        else $error("R4: external output enable active in register window");
      p_pf_blocks_r6: assert (!pwr_fail_i ||
                              (reg_wr_stb_o == '0 && ext_we_n_o && ext_ce_n_o))
        else $error("R6: write or chip enable escaped during power fail");
      p_bus_quiet_wr_r8: assert (!rdata_oe_o ||
                                 (reg_wr_stb_o == '0 && ext_we_n_o))
        else $error("R8: bus driven during a write");
      p_reg_wr_no_ext_r10: assert (reg_wr_stb_o == '0 || ext_we_n_o)
        else $error("R10: register write leaked to external memory");
    end
  end

endmodule

// File: tb/sim_bbsg_top.sv
module sim_bbsg_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [18:0] addr_i = '0;
  logic ce_n_i = 1'b1, oe_n_i = 1'b1, we_n_i = 1'b1, pwr_fail_i = 1'b0;
  logic [7:0] mem_rdata_i = 8'h3C, reg_rdata_i = 8'hA5;
  logic ext_ce_n_o, ext_oe_n_o, ext_we_n_o, rdata_oe_o;
  logic [3:0] reg_idx_o;
  logic [15:0] reg_wr_stb_o, reg_rd_stb_o;
  logic [7:0] rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bbsg_top u0 (.*);

  // Vector: addr[28:10], {ce,oe,we,pf}[9:6], expected {ece,eoe,ewe,doe,wr_any,rd_any}[5:0]
  localparam logic [28:0] VEC [NVEC] = '{
    {19'h00000, 4'b0010, 6'b001100},  // memory read
    {19'h7FFF5, 4'b0010, 6'b011101},  // register read
    {19'h7FFEF, 4'b0010, 6'b001100},  // last memory address
    {19'h12345, 4'b0100, 6'b010000},  // memory write
    {19'h7FFF0, 4'b0100, 6'b011010},  // register write, first slot
    {19'h7FFFF, 4'b0000, 6'b011010},  // register write, oe low
    {19'h12345, 4'b0001, 6'b101000},  // memory write under power fail
    {19'h7FFF8, 4'b0101, 6'b111000},  // register write under power fail
    {19'h7FFF3, 4'b1010, 6'b111000},  // deselected, window
    {19'h00100, 4'b1000, 6'b101000},  // deselected, memory, we low
    {19'h7FFF9, 4'b0110, 6'b011001},  // register read, oe high
    {19'h3FFFF, 4'b0110, 6'b011000},  // memory read, oe high
    {19'h7FFFF, 4'b0011, 6'b111101}   // register read under power fail
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    settle();
    // Reset/idle state: deselected bus
    check("R7", "idle ext_ce_n", ext_ce_n_o, 1);
    check("R8", "idle rdata_oe", rdata_oe_o, 0);
    check("R2", "idle wr_stb", reg_wr_stb_o, 0);
    check("R10", "idle ext_we_n", ext_we_n_o, 1);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [28:0] v;
      v = VEC[i];
      addr_i = v[28:10];
      {ce_n_i, oe_n_i, we_n_i, pwr_fail_i} = v[9:6];
      settle();
      check("R7_R6", $sformatf("vec%0d ext_ce_n", i), ext_ce_n_o, v[5]);
      check("R4_R5", $sformatf("vec%0d ext_oe_n", i), ext_oe_n_o, v[4]);
      check("R10", $sformatf("vec%0d ext_we_n", i), ext_we_n_o, v[3]);
      check("R8", $sformatf("vec%0d rdata_oe", i), rdata_oe_o, v[2]);
      check("R2", $sformatf("vec%0d wr_any", i), |reg_wr_stb_o, v[1]);
      check("R3", $sformatf("vec%0d rd_any", i), |reg_rd_stb_o, v[0]);
    end

    // R1/R2/R3: every slot gets its own strobe bit
    pwr_fail_i = 0; ce_n_i = 0; oe_n_i = 1;
    for (int s = 0; s < 16; s++) begin
      addr_i = 19'h7FFF0 + 19'(s);
      we_n_i = 0;
      settle();
      check("R1", "slot index", reg_idx_o, s);
      check("R2", "write strobe one-hot", reg_wr_stb_o, 32'(16'h1 << s));
      we_n_i = 1;
      settle();
      check("R3", "read strobe one-hot", reg_rd_stb_o, 32'(16'h1 << s));
    end

    // R9: read data source at the window boundary
    we_n_i = 1; oe_n_i = 0;
    addr_i = 19'h7FFEF; settle();
    check("R9", "rdata below window", rdata_o, 8'h3C);
    check("R1", "no strobe below window", reg_rd_stb_o, 0);
    addr_i = 19'h7FFF0; settle();
    check("R9", "rdata in window", rdata_o, 8'hA5);
    reg_rdata_i = 8'h5A; settle();
    check("R9", "rdata follows register data", rdata_o, 8'h5A);

    // R5: address move within one cycle, no edge between
    @(posedge clk); #1;
    addr_i = 19'h0F0F0; #1;
    check("R5", "oe passes in memory range", ext_oe_n_o, 0);
    addr_i = 19'h7FFF4; #1;
    check("R5", "oe drops on move into window", ext_oe_n_o, 1);
    oe_n_i = 1; addr_i = 19'h0F0F0; #1;
    check("R5", "oe high passes", ext_oe_n_o, 1);

    // R6: power fail rising during a memory write in progress
    oe_n_i = 1; we_n_i = 0; addr_i = 19'h00042; settle();
    check("R10", "memory write active", ext_we_n_o, 0);
    pwr_fail_i = 1; #1;
    check("R6", "pf cuts ext_we_n", ext_we_n_o, 1);
    check("R6", "pf cuts ext_ce_n", ext_ce_n_o, 1);
    addr_i = 19'h7FFF2; #1;
    check("R6", "pf blocks register write", reg_wr_stb_o, 0);
    pwr_fail_i = 0; #1;
    check("R2", "register write after pf clears", reg_wr_stb_o, 32'h4);
    check("R10", "register write keeps ext_we_n", ext_we_n_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule